// File: doc/BRIEF.md
# Tap Delay Line

This block is a serial bit delay line with a tap that can be moved while it runs. Each enabled clock edge moves every stored bit one stage further along a chain of `DEPTH` stages (16 by default). A select input picks which stage drives the tap output. The delay can therefore be set anywhere from one cycle up to the full chain length. Changing the select does not flush or reload the stored data.

The typical use is to balance pipeline branches whose latencies differ. The delay of the shorter branch is set to match the longer one, and it can be retuned at runtime. The final stage is always brought out on a separate chain output, so two or more instances can be connected in series for longer delays. A wider data path is built by placing one instance per bit.

A parameter selects an optional registered tap. In that mode, one more flop follows the selector, so the delay grows by one cycle and the tap no longer has a combinational path from the select input.

Top module: `tap_delay_line`

## Requirements
- R1: At power-up every stage holds 0. Before the first enabled edge, `tap_out` and `chain_out` read 0 for every `tap_sel` value.
- R2: In the default combinational-tap mode, a select value N (stage N, counted from 0 at the input) gives `tap_out` equal to the `din` bit captured N+1 enabled edges earlier.
- R3: While `shift_en` is 0, clock edges change no stage, whatever `din` does. The outputs keep their values as long as `tap_sel` does not change.
- R4: A change of `tap_sel` with no clock edge between reaches `tap_out` in the same cycle. It shows the sample already held at the new depth and does not disturb the stored data.
- R5: `chain_out` always carries the last stage. It equals the `din` bit captured `DEPTH` enabled edges earlier, for any `tap_sel`.
- R6: When `chain_out` of one instance feeds `din` of a second instance that shares its enable, the second instance's tap at select N gives a total delay of `DEPTH`+N+1 enabled edges.
- R7: In registered-tap mode, `tap_out` updates only on enabled edges, capturing the stage selected at that edge. The delay is N+2 enabled edges, and `tap_out` starts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| shift_en | input | 1 | Advances the chain by one stage when high |
| din | input | 1 | Serial data into stage 0 |
| tap_sel | input | log2(DEPTH) | Index of the stage driving the tap |
| tap_out | output | 1 | Selected stage, directly or through the optional flop |
| chain_out | output | 1 | Last stage, for cascading |

## Verification
A corrupted stage is visible at `tap_out` as soon as `tap_sel` points at it, with no clock needed. If nothing selects it, it reaches `chain_out` after at most `DEPTH` more enabled edges. Each edge in which the enable is wrongly ignored or wrongly obeyed shifts the whole stored history by one sample. A sweep over every select value therefore exposes it within one clock. Errors in the selector show up immediately at a single select value. Errors in the cascade path or the output flop show up as an off-by-one delay at the second instance or the registered instance.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

   typedef enum logic {
      TAP_COMB = 1'b0,
      TAP_REG  = 1'b1
   } tap_mode_e;

   function automatic int unsigned sel_width(input int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/tdl_stage_chain.sv
module tdl_stage_chain #(
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             shift_en,
   input  logic             din,
   output logic [DEPTH-1:0] taps
);

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic src;
      logic bit_r = 1'b0;

      if (i == 0) begin : g_head
         assign src = din;
      end else begin : g_body
         assign src = taps[i-1];
      end

      always_ff @(posedge clk) begin
         if (shift_en) bit_r <= src;
      end

      assign taps[i] = bit_r;

      if (i > 0) begin : g_step_chk
         // R2
         stage_step_chk: assert property (@(posedge clk) disable iff (!armed)
            shift_en |=> taps[i] == $past(taps[i-1]));
      end
   end

   // R2
   head_capture_chk: assert property (@(posedge clk) disable iff (!armed)
      shift_en |=> taps[0] == $past(din));

   // R3
   frozen_chain_chk: assert property (@(posedge clk) disable iff (!armed)
      !shift_en |=> $stable(taps));

endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned SEL_W = 4
) (
   input  logic [DEPTH-1:0] taps,
   input  logic [SEL_W-1:0] sel,
   output logic             y
);

   logic [DEPTH-1:0] hit;

   for (genvar i = 0; i < DEPTH; i++) begin : g_leg
      assign hit[i] = taps[i] & (sel == SEL_W'(i));
   end

   assign y = |hit;

endmodule

// File: rtl/tdl_out_stage.sv
module tdl_out_stage (
   input  logic clk,
   input  logic shift_en,
   input  logic d,
   output logic y
);

   logic armed = 1'b0;
   logic q_r   = 1'b0;

   always_ff @(posedge clk) armed <= 1'b1;

   always_ff @(posedge clk) begin
      if (shift_en) q_r <= d;
   end

   assign y = q_r;

   // R7
   out_load_chk: assert property (@(posedge clk) disable iff (!armed)
      shift_en |=> y == $past(d));

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!armed)
      !shift_en |=> $stable(y));

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
   parameter int unsigned        DEPTH    = 16,
   parameter tdl_pkg::tap_mode_e TAP_MODE = tdl_pkg::TAP_COMB,
   localparam int unsigned       SEL_W    = tdl_pkg::sel_width(DEPTH)
) (
   input  logic             clk,
   input  logic             shift_en,
   input  logic             din,
   input  logic [SEL_W-1:0] tap_sel,
   output logic             tap_out,
   output logic             chain_out
);

   if (DEPTH < 2) begin : g_depth_min_bad
      $error("tap_delay_line: DEPTH must be at least 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_depth_pow2_bad
      $error("tap_delay_line: DEPTH must be a power of two");
   end

   logic [DEPTH-1:0] taps;
   logic             tap_comb;

   tdl_stage_chain #(.DEPTH(DEPTH)) u_chain (
      .clk      (clk),
      .shift_en (shift_en),
      .din      (din),
      .taps     (taps)
   );

   tdl_tap_mux #(.DEPTH(DEPTH), .SEL_W(SEL_W)) u_mux (
      .taps (taps),
      .sel  (tap_sel),
      .y    (tap_comb)
   );

   assign chain_out = taps[DEPTH-1];

   if (TAP_MODE == tdl_pkg::TAP_REG) begin : g_reg_tap
      tdl_out_stage u_out (
         .clk      (clk),
         .shift_en (shift_en),
         .d        (tap_comb),
         .y        (tap_out)
      );
   end else begin : g_comb_tap
      assign tap_out = tap_comb;
   end

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   // R5
   last_tap_agree_chk: assert property (@(posedge clk) disable iff (!armed)
      (tap_sel == SEL_W'(DEPTH - 1)) |-> tap_comb == chain_out);

   // R3
   chain_hold_chk: assert property (@(posedge clk) disable iff (!armed)
      !shift_en |=> $stable(chain_out));

   // R3
   tap_hold_chk: assert property (@(posedge clk) disable iff (!armed)
      !shift_en ##1 $stable(tap_sel) |-> $stable(tap_out));

endmodule

// File: tb/tap_delay_line_tb_top.sv
module tap_delay_line_tb_top;

   logic       clk = 1'b0;
   logic       shift_en = 1'b0;
   logic       din = 1'b0;
   logic [3:0] tap_sel = 4'd0;
   logic       tap_out, chain_out;
   logic       casc_tap, casc_chain;
   logic       reg_tap, reg_chain;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit        mdl [32];
   bit        reg_exp = 1'b0;
   bit [15:0] lf = 16'hACE1;

   always #10 clk = ~clk;

   tap_delay_line #(.DEPTH(16), .TAP_MODE(tdl_pkg::TAP_COMB)) dut_i (
      .clk(clk), .shift_en(shift_en), .din(din), .tap_sel(tap_sel),
      .tap_out(tap_out), .chain_out(chain_out));

   tap_delay_line #(.DEPTH(16), .TAP_MODE(tdl_pkg::TAP_COMB)) casc_i (
      .clk(clk), .shift_en(shift_en), .din(chain_out), .tap_sel(tap_sel),
      .tap_out(casc_tap), .chain_out(casc_chain));

   tap_delay_line #(.DEPTH(16), .TAP_MODE(tdl_pkg::TAP_REG)) reg_i (
      .clk(clk), .shift_en(shift_en), .din(din), .tap_sel(tap_sel),
      .tap_out(reg_tap), .chain_out(reg_chain));

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b sel=%0d t=%0t", tag, act, exp, tap_sel, $time);
      end
   endtask

   function automatic bit [15:0] lf_next(input bit [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   task automatic check_all();
      chk("R2 tap delay", tap_out, mdl[tap_sel]);
      chk("R5 chain out", chain_out, mdl[15]);
      chk("R6 cascade", casc_tap, mdl[16 + int'(tap_sel)]);
      chk("R7 registered tap", reg_tap, reg_exp);
   endtask

   task automatic cycle(input bit en, input bit d, input logic [3:0] s);
      @(negedge clk);
      shift_en = en;
      din      = d;
      tap_sel  = s;
      @(posedge clk);
      if (en) begin
         reg_exp = mdl[s];
         for (int k = 31; k > 0; k--) mdl[k] = mdl[k-1];
         mdl[0] = d;
      end
      #5;
      check_all();
   endtask

   initial begin
      logic held_tap, held_chain;
      for (int k = 0; k < 32; k++) mdl[k] = 1'b0;

      // R1: power-up zeros at every select, before the first edge
      #2;
      for (int s = 0; s < 16; s++) begin
         tap_sel = 4'(s);
         #0.5;
         chk("R1 power-up tap", tap_out, 1'b0);
         chk("R1 power-up chain", chain_out, 1'b0);
         chk("R1 power-up reg tap", reg_tap, 1'b0);
      end

      // R2 R5 R6 R7: fixed-depth sweep over every select value
      for (int s = 0; s < 16; s++) begin
         for (int c = 0; c < 40; c++) begin
            lf = lf_next(lf);
            cycle(1'b1, lf[0], 4'(s));
         end
      end

      // R4: select changes every cycle while shifting
      for (int c = 0; c < 200; c++) begin
         lf = lf_next(lf);
         cycle(1'b1, lf[0], lf[7:4]);
      end

      // R3: irregular enable pattern, din keeps toggling
      for (int c = 0; c < 200; c++) begin
         lf = lf_next(lf);
         cycle(lf[3] & lf[9], lf[0], lf[11:8]);
      end

      // R3: long stall with din and clock active, fixed select
      cycle(1'b1, 1'b1, 4'd5);
      held_tap   = tap_out;
      held_chain = chain_out;
      for (int c = 0; c < 8; c++) begin
         cycle(1'b0, c[0], 4'd5);
         chk("R3 stall tap", tap_out, held_tap);
         chk("R3 stall chain", chain_out, held_chain);
      end

      // R4: select moves between edges, no clock, data must stay put
      @(negedge clk);
      shift_en = 1'b0;
      for (int s = 15; s >= 0; s--) begin
         tap_sel = 4'(s);
         #0.5;
         chk("R4 immediate select", tap_out, mdl[s]);
         chk("R4 cascade select", casc_tap, mdl[16 + s]);
      end
      tap_sel = 4'd3;
      #0.5;
      chk("R4 reselect", tap_out, mdl[3]);
      @(posedge clk);
      #5;
      check_all();

      // resume shifting after the stall to confirm nothing was lost
      for (int c = 0; c < 40; c++) begin
         lf = lf_next(lf);
         cycle(1'b1, lf[0], 4'(c % 16));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(64'd200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule